// File: doc/BRIEF.md
# Floating-Point Rounding Mode and Exception Flag Control

This block keeps the floating-point control state of a processor core. It has a 3-bit dynamic rounding-mode register and a 5-bit register of sticky exception flags. Every floating-point instruction carries a 3-bit static rounding field. The block turns that field into the effective rounding mode that goes to the arithmetic units. When the field names no legal mode, the block raises an illegal-instruction indication instead.

Completing operations report their exception flags on a one-cycle strobe, and the block ORs them into the sticky register. Software reaches the state through a small register port. The port selects the flag field, the mode field, or an 8-bit combined view, and applies one of four operations: write, set, clear, or read only. The read data always shows the current value of the selected view.

Top module: `fpctl_top`

## Requirements
- R1: A valid instruction whose static field is 0 (nearest-even), 1 (toward zero), 2 (down), 3 (up) or 4 (nearest, ties away) drives `rm_eff` to that value in the same cycle, with `rm_illegal` low.
- R2: A static field of 7 drives `rm_eff` to the value held in the dynamic mode register, provided that value is 0 to 4.
- R3: The resolved value is illegal when it is 5 or 6 in the static field, or 5 to 7 in the dynamic register when the static field is 7. For a valid instruction with an illegal value, `rm_illegal` is high and `rm_eff` is 0. `rm_illegal` is never high while `insn_vld` is low.
- R4: When `fp_done` is high, `fp_flags` is ORed into the flag register at the next clock edge. The bit positions are inexact=0, underflow=1, overflow=2, divide-by-zero=3 and invalid=4. A flag bit stays set until software clears it.
- R5: A write (`csr_op`=0) to the flag field (`csr_sel`=0) replaces all five flags with `csr_wdata[4:0]` at the next edge.
- R6: Set (`csr_op`=1) ORs the write data into the selected field. Clear (`csr_op`=2) clears each bit of the field whose write-data bit is 1. Both apply to the flag field and to the mode field.
- R7: When a software write, set or clear of the flag field and an `fp_done` update happen in the same cycle, only the software result is stored. A software access to the mode field alone does not block the hardware flag merge.
- R8: The combined view (`csr_sel`=2) reads {mode, flags}, with the mode in bits 7:5 and the flags in bits 4:0. An operation on the combined view updates both fields from those bit slices.
- R9: The mode view (`csr_sel`=1) reads the mode in bits 2:0 with bits 7:3 zero. Operations on it use `csr_wdata[2:0]`. The mode register holds any 3-bit value, 5 to 7 included.
- R10: After reset, both the flags and the dynamic mode are 0.
- R11: `csr_en` low, `csr_op`=3, or `csr_sel`=3 leaves both fields unchanged. `csr_sel`=3 reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| insn_vld | input | 1 | A floating-point instruction requests a rounding mode |
| insn_rm | input | 3 | Static rounding field of the instruction |
| rm_eff | output | 3 | Effective rounding mode (0 when illegal) |
| rm_illegal | output | 1 | Illegal-instruction indication |
| fp_done | input | 1 | A completing operation reports flags |
| fp_flags | input | 5 | Flags reported by the completing operation |
| csr_en | input | 1 | Register port access strobe |
| csr_sel | input | 2 | View select: 0 flags, 1 mode, 2 combined, 3 none |
| csr_op | input | 2 | Operation: 0 write, 1 set, 2 clear, 3 read only |
| csr_wdata | input | 8 | Write data |
| csr_rdata | output | 8 | Current value of the selected view |

## Verification
The resolver is driven with every static code. Codes 0 to 4 show the pass-through path, 5 and 6 show the reserved-code trap, and 7 is paired with dynamic values both inside and outside the legal range. This separates deferral from trapping. Flag sequences with disjoint and repeated bits show that flags are ORed and sticky rather than overwritten. Same-cycle collisions of software and hardware flag updates, on the flag field and on the mode field, show which path wins. Write, set and clear are applied through each view, and read-only, disabled and reserved-select accesses carrying all-ones data show that these accesses leave the state untouched.

// File: rtl/fpctl_pkg.sv
package fpctl_pkg;

    parameter int RM_W   = 3;
    parameter int FLAG_W = 5;
    parameter int NUM_RM = 5;
    parameter int DYN_RM = 7;

    localparam int VIEW_W = RM_W + FLAG_W;

    localparam int FLAG_NX = 0;
    localparam int FLAG_UF = 1;
    localparam int FLAG_OF = 2;
    localparam int FLAG_DZ = 3;
    localparam int FLAG_NV = 4;

    typedef enum logic [1:0] {
        SEL_FLAGS = 2'd0,
        SEL_MODE  = 2'd1,
        SEL_BOTH  = 2'd2,
        SEL_NONE  = 2'd3
    } view_sel_e;

    typedef enum logic [1:0] {
        OP_WRITE = 2'd0,
        OP_SET   = 2'd1,
        OP_CLEAR = 2'd2,
        OP_READ  = 2'd3
    } field_op_e;

endpackage

// File: rtl/fpctl_field_alu.sv
module fpctl_field_alu #(
    parameter int W = 5
) (
    input  logic [1:0]   op,
    input  logic [W-1:0] cur,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] nxt
);
    import fpctl_pkg::*;

    always_comb begin
        unique case (field_op_e'(op))
            OP_WRITE: nxt = wdata;
            OP_SET:   nxt = cur | wdata;
            OP_CLEAR: nxt = cur & ~wdata;
            default:  nxt = cur;
        endcase
    end

endmodule

// File: rtl/fpctl_rm_resolve.sv
module fpctl_rm_resolve #(
    parameter int RM_W   = 3,
    parameter int NUM_RM = 5,
    parameter int DYN_RM = 7
) (
    input  logic            insn_vld,
    input  logic [RM_W-1:0] insn_rm,
    input  logic [RM_W-1:0] dyn_rm,
    output logic [RM_W-1:0] rm_eff,
    output logic            rm_illegal
);
    localparam logic [RM_W-1:0] DYN_CODE  = RM_W'(DYN_RM);
    localparam logic [RM_W-1:0] LIMIT     = RM_W'(NUM_RM);

    logic [RM_W-1:0] picked;
    logic            legal;

    always_comb begin
        picked     = (insn_rm == DYN_CODE) ? dyn_rm : insn_rm;
        legal      = (picked < LIMIT);
        rm_eff     = legal ? picked : '0;
        rm_illegal = insn_vld && !legal;
    end

endmodule

// File: rtl/fpctl_flag_reg.sv
module fpctl_flag_reg #(
    parameter int FLAG_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_we,
    input  logic [FLAG_W-1:0] sw_val,
    input  logic              hw_vld,
    input  logic [FLAG_W-1:0] hw_flags,
    output logic [FLAG_W-1:0] flags_q
);
    typedef struct packed {
        logic [FLAG_W-1:0] flags;
    } flag_state_t;

    flag_state_t       st_d, st_q;
    logic [FLAG_W-1:0] bit_nxt;

    for (genvar i = 0; i < FLAG_W; i++) begin : g_bit
        assign bit_nxt[i] = sw_we ? sw_val[i]
                                  : (st_q.flags[i] | (hw_vld & hw_flags[i]));
    end

    always_comb begin
        st_d       = st_q;
        st_d.flags = bit_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flags_q = st_q.flags;

    // R7
    sw_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sw_we |=> flags_q == $past(sw_val));

    // R4
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_we |=> (flags_q & $past(flags_q)) == $past(flags_q));

    // R4
    merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_we && hw_vld) |=> flags_q == ($past(flags_q) | $past(hw_flags)));

endmodule

// File: rtl/fpctl_mode_reg.sv
module fpctl_mode_reg #(
    parameter int RM_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sw_we,
    input  logic [RM_W-1:0] sw_val,
    output logic [RM_W-1:0] mode_q
);
    typedef struct packed {
        logic [RM_W-1:0] mode;
    } mode_state_t;

    mode_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (sw_we) begin
            st_d.mode = sw_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_q = st_q.mode;

    // R9
    mode_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sw_we |=> mode_q == $past(sw_val));

    // R11
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_we |=> mode_q == $past(mode_q));

endmodule

// File: rtl/fpctl_top.sv
module fpctl_top
    import fpctl_pkg::*;
#(
    parameter int P_RM_W   = RM_W,
    parameter int P_FLAG_W = FLAG_W,
    parameter int P_NUM_RM = NUM_RM,
    parameter int P_DYN_RM = DYN_RM
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       insn_vld,
    input  logic [P_RM_W-1:0]          insn_rm,
    output logic [P_RM_W-1:0]          rm_eff,
    output logic                       rm_illegal,
    input  logic                       fp_done,
    input  logic [P_FLAG_W-1:0]        fp_flags,
    input  logic                       csr_en,
    input  logic [1:0]                 csr_sel,
    input  logic [1:0]                 csr_op,
    input  logic [P_RM_W+P_FLAG_W-1:0] csr_wdata,
    output logic [P_RM_W+P_FLAG_W-1:0] csr_rdata
);
    localparam int VW = P_RM_W + P_FLAG_W;
    localparam logic [P_RM_W-1:0] LIMIT = P_RM_W'(P_NUM_RM);
    localparam logic [P_RM_W-1:0] DYN   = P_RM_W'(P_DYN_RM);

    logic [P_RM_W-1:0]   mode_q;
    logic [P_FLAG_W-1:0] flags_q;
    logic                modifies;
    logic                hit_flags;
    logic                hit_mode;
    logic [P_RM_W-1:0]   mode_src;
    logic [P_FLAG_W-1:0] flag_src;
    logic [P_RM_W-1:0]   mode_nxt;
    logic [P_FLAG_W-1:0] flag_nxt;

    always_comb begin
        modifies  = csr_en && (field_op_e'(csr_op) != OP_READ);
        hit_flags = modifies && (view_sel_e'(csr_sel) == SEL_FLAGS ||
                                 view_sel_e'(csr_sel) == SEL_BOTH);
        hit_mode  = modifies && (view_sel_e'(csr_sel) == SEL_MODE ||
                                 view_sel_e'(csr_sel) == SEL_BOTH);
        flag_src  = csr_wdata[P_FLAG_W-1:0];
        mode_src  = (view_sel_e'(csr_sel) == SEL_BOTH) ? csr_wdata[VW-1:P_FLAG_W]
                                                       : csr_wdata[P_RM_W-1:0];
    end

    always_comb begin
        unique case (view_sel_e'(csr_sel))
            SEL_FLAGS: csr_rdata = VW'(flags_q);
            SEL_MODE:  csr_rdata = VW'(mode_q);
            SEL_BOTH:  csr_rdata = {mode_q, flags_q};
            default:   csr_rdata = '0;
        endcase
    end

    fpctl_field_alu #(.W(P_FLAG_W)) i_flag_alu (
        .op    (csr_op),
        .cur   (flags_q),
        .wdata (flag_src),
        .nxt   (flag_nxt)
    );

    fpctl_field_alu #(.W(P_RM_W)) i_mode_alu (
        .op    (csr_op),
        .cur   (mode_q),
        .wdata (mode_src),
        .nxt   (mode_nxt)
    );

    fpctl_flag_reg #(.FLAG_W(P_FLAG_W)) i_flag_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .sw_we    (hit_flags),
        .sw_val   (flag_nxt),
        .hw_vld   (fp_done),
        .hw_flags (fp_flags),
        .flags_q  (flags_q)
    );

    fpctl_mode_reg #(.RM_W(P_RM_W)) i_mode_reg (
        .clk    (clk),
        .rst_n  (rst_n),
        .sw_we  (hit_mode),
        .sw_val (mode_nxt),
        .mode_q (mode_q)
    );

    fpctl_rm_resolve #(
        .RM_W   (P_RM_W),
        .NUM_RM (P_NUM_RM),
        .DYN_RM (P_DYN_RM)
    ) i_resolve (
        .insn_vld   (insn_vld),
        .insn_rm    (insn_rm),
        .dyn_rm     (mode_q),
        .rm_eff     (rm_eff),
        .rm_illegal (rm_illegal)
    );

    // R1
    static_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_vld && insn_rm < LIMIT) |-> (rm_eff == insn_rm && !rm_illegal));

    // R2
    dyn_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_vld && insn_rm == DYN && mode_q < LIMIT) |-> (rm_eff == mode_q && !rm_illegal));

    // R3
    reserved_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_vld && insn_rm >= LIMIT && insn_rm != DYN) |-> (rm_illegal && rm_eff == '0));

    // R3
    no_spurious_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !insn_vld |-> !rm_illegal);

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!csr_en && !fp_done) |=> (flags_q == $past(flags_q) && mode_q == $past(mode_q)));

endmodule

// File: tb/test_fpctl_top.sv
module test_fpctl_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       insn_vld = 1'b0;
    logic [2:0] insn_rm = '0;
    logic [2:0] rm_eff;
    logic       rm_illegal;
    logic       fp_done = 1'b0;
    logic [4:0] fp_flags = '0;
    logic       csr_en = 1'b0;
    logic [1:0] csr_sel = '0;
    logic [1:0] csr_op = 2'd3;
    logic [7:0] csr_wdata = '0;
    logic [7:0] csr_rdata;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    fpctl_top i_fpctl_top (
        .clk        (clk),
        .rst_n      (rst_n),
        .insn_vld   (insn_vld),
        .insn_rm    (insn_rm),
        .rm_eff     (rm_eff),
        .rm_illegal (rm_illegal),
        .fp_done    (fp_done),
        .fp_flags   (fp_flags),
        .csr_en     (csr_en),
        .csr_sel    (csr_sel),
        .csr_op     (csr_op),
        .csr_wdata  (csr_wdata),
        .csr_rdata  (csr_rdata)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic csr_do(input logic [1:0] sel, input logic [1:0] op, input logic [7:0] d);
        @(negedge clk);
        csr_en = 1'b1; csr_sel = sel; csr_op = op; csr_wdata = d;
        @(negedge clk);
        csr_en = 1'b0; csr_op = 2'd3; csr_wdata = '0;
    endtask

    task automatic csr_rd(input logic [1:0] sel, output logic [7:0] v);
        csr_sel = sel;
        #1;
        v = csr_rdata;
    endtask

    task automatic hw_report(input logic [4:0] f);
        @(negedge clk);
        fp_done = 1'b1; fp_flags = f;
        @(negedge clk);
        fp_done = 1'b0; fp_flags = '0;
    endtask

    task automatic probe(input string req, input logic vld, input logic [2:0] rm,
                         input logic [2:0] exp_eff, input logic exp_ill);
        insn_vld = vld; insn_rm = rm;
        #1;
        if (vld) check(req, {5'b0, rm_eff}, {5'b0, exp_eff});
        check(req, {7'b0, rm_illegal}, {7'b0, exp_ill});
        insn_vld = 1'b0;
    endtask

    task automatic t_reset;
        logic [7:0] v;
        csr_rd(2'd2, v);
        check("R10 reset state", v, 8'h00);
    endtask

    task automatic t_static;
        for (int r = 0; r < 5; r++) begin
            probe("R1 static mode", 1'b1, 3'(r), 3'(r), 1'b0);
        end
    endtask

    task automatic t_dynamic;
        logic [7:0] v;
        csr_do(2'd1, 2'd0, 8'h03);
        probe("R2 defer to dynamic 3", 1'b1, 3'd7, 3'd3, 1'b0);
        csr_do(2'd1, 2'd0, 8'hFC);
        probe("R2 defer to dynamic 4", 1'b1, 3'd7, 3'd4, 1'b0);
        csr_rd(2'd1, v);
        check("R9 mode view upper bits zero", v, 8'h04);
    endtask

    task automatic t_illegal;
        logic [7:0] v;
        probe("R3 static 5", 1'b1, 3'd5, 3'd0, 1'b1);
        probe("R3 static 6", 1'b1, 3'd6, 3'd0, 1'b1);
        probe("R3 no trap without insn_vld", 1'b0, 3'd5, 3'd0, 1'b0);
        for (int m = 5; m < 8; m++) begin
            csr_do(2'd1, 2'd0, 8'(m));
            probe("R3 dynamic reserved", 1'b1, 3'd7, 3'd0, 1'b1);
            csr_rd(2'd1, v);
            check("R9 mode holds reserved value", v, 8'(m));
        end
        probe("R1 static unaffected by reserved dyn", 1'b1, 3'd2, 3'd2, 1'b0);
    endtask

    task automatic t_hw_flags;
        logic [7:0] v;
        csr_do(2'd0, 2'd0, 8'h00);
        hw_report(5'b00001);
        csr_rd(2'd0, v);
        check("R4 merge NX", v, 8'h01);
        hw_report(5'b10000);
        csr_rd(2'd0, v);
        check("R4 merge NV sticky NX", v, 8'h11);
        hw_report(5'b00000);
        csr_rd(2'd0, v);
        check("R4 empty report keeps flags", v, 8'h11);
        hw_report(5'b10100);
        csr_rd(2'd0, v);
        check("R4 merge OF repeat NV", v, 8'h15);
    endtask

    task automatic t_sw_ops;
        logic [7:0] v;
        csr_do(2'd0, 2'd0, 8'h0A);
        csr_rd(2'd0, v);
        check("R5 flag write replaces", v, 8'h0A);
        csr_do(2'd0, 2'd1, 8'h01);
        csr_rd(2'd0, v);
        check("R6 flag set", v, 8'h0B);
        csr_do(2'd0, 2'd2, 8'h02);
        csr_rd(2'd0, v);
        check("R6 flag clear", v, 8'h09);
        csr_do(2'd1, 2'd0, 8'h01);
        csr_do(2'd1, 2'd1, 8'h02);
        csr_rd(2'd1, v);
        check("R6 mode set", v, 8'h03);
        csr_do(2'd1, 2'd2, 8'h01);
        csr_rd(2'd1, v);
        check("R6 mode clear", v, 8'h02);
    endtask

    task automatic t_priority;
        logic [7:0] v;
        @(negedge clk);
        csr_en = 1'b1; csr_sel = 2'd0; csr_op = 2'd0; csr_wdata = 8'h04;
        fp_done = 1'b1; fp_flags = 5'b10011;
        @(negedge clk);
        csr_en = 1'b0; csr_op = 2'd3; fp_done = 1'b0; fp_flags = '0;
        csr_rd(2'd0, v);
        check("R7 software write wins", v, 8'h04);
        @(negedge clk);
        csr_en = 1'b1; csr_sel = 2'd1; csr_op = 2'd0; csr_wdata = 8'h01;
        fp_done = 1'b1; fp_flags = 5'b10000;
        @(negedge clk);
        csr_en = 1'b0; csr_op = 2'd3; fp_done = 1'b0; fp_flags = '0;
        csr_rd(2'd0, v);
        check("R7 mode access keeps merge", v, 8'h14);
        csr_rd(2'd1, v);
        check("R7 mode write same cycle", v, 8'h01);
    endtask

    task automatic t_combined;
        logic [7:0] v;
        csr_do(2'd2, 2'd0, 8'hA5);
        csr_rd(2'd2, v);
        check("R8 combined write/read", v, 8'hA5);
        csr_rd(2'd0, v);
        check("R8 flags slice", v, 8'h05);
        csr_rd(2'd1, v);
        check("R8 mode slice", v, 8'h05);
        csr_do(2'd2, 2'd2, 8'h81);
        csr_rd(2'd2, v);
        check("R8 combined clear", v, 8'h24);
    endtask

    task automatic t_ignore;
        logic [7:0] v;
        csr_do(2'd2, 2'd3, 8'hFF);
        csr_rd(2'd2, v);
        check("R11 read-only op", v, 8'h24);
        csr_do(2'd3, 2'd0, 8'hFF);
        csr_rd(2'd2, v);
        check("R11 reserved select write", v, 8'h24);
        csr_rd(2'd3, v);
        check("R11 reserved select reads zero", v, 8'h00);
        @(negedge clk);
        csr_en = 1'b0; csr_sel = 2'd2; csr_op = 2'd0; csr_wdata = 8'hFF;
        @(negedge clk);
        csr_op = 2'd3; csr_wdata = '0;
        csr_rd(2'd2, v);
        check("R11 disabled port", v, 8'h24);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_static();
        t_dynamic();
        t_illegal();
        t_hw_flags();
        t_sw_ops();
        t_priority();
        t_combined();
        t_ignore();
        @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule